// File: doc/BRIEF.md
# System Control Register Bank

This block holds the thirty-two system-control registers of a 64-bit processor core. A 5-bit register number selects each one. The core writes a register through a move-to port and reads one through a move-from port. Each port works in a 64-bit form and in a 32-bit form. In the 32-bit form a write stores the low half of the source zero-extended, and a read returns bit 31 copied into the upper half.

The registers are not all plain storage. Some translation registers keep only the bits their mask allows. The replacement-index, processor-identity and configuration slots ignore every write. The replacement index is computed from a free-running counter and is never allowed to fall below the Wired register. A Count/Compare timer raises a timer interrupt and holds it until Compare is written. The bank also derives a pending-interrupt flag from Status and Cause. Finally, it decodes the privilege mode from Status and flags a privileged access made outside kernel mode.

Slot numbering follows this order:

| Slots | Registers |
|-------|-----------|
| 0 to 7 | index, random, lo0, lo1, context, page mask, wired, info |
| 8 to 15 | bad address, count, hi, compare, status, cause, epc, identity |
| 16 to 20 | config, link address, watch low, watch high, extended context |
| 21 to 25 | reserved |
| 26 to 30 | ecc, cache error, tag low, tag high, error epc |
| 31 | reserved |

Top module: `sysctl_regbank`

## Requirements
- R1: After reset every slot reads zero, with these exceptions. The identity slot (15) reads the PRID_VAL parameter and the configuration slot (16) reads the CONFIG_VAL parameter. Slots 1 and 9 are excluded because they change on their own.
- R2: Writes to slots 1, 15 and 16 have no effect.
- R3: The replacement index (the rand_idx port, also readable at slot 1) equals Wired + (F mod (TLB_ENTRIES − Wired)). F is a counter that advances every clock. The result therefore lies in [Wired, TLB_ENTRIES−1]. When Wired ≥ TLB_ENTRIES−1 the index is TLB_ENTRIES−1.
- R4: Some slots store only the bits their mask allows:
  - Page mask (5) keeps 0x0000_0000_01FF_E000.
  - Hi (10) keeps 0xC000_00FF_FFFF_E0FF.
  - Lo0 and lo1 (2, 3) keep 0x0000_0000_3FFF_FFFF.
  - Wired (6) keeps its low log2(TLB_ENTRIES) bits.
- R5: A 64-bit move-to stores all 64 source bits, subject to R4. A 32-bit move-to stores the low 32 bits zero-extended.
- R6: A 32-bit move-from returns bit 31 copied into bits 63:32. Count (9) and Compare (11) hold 32 bits and always read sign-extended, even through a 64-bit move-from.
- R7: Count advances by one every DIVISOR clocks. Writing Count loads the low 32 bits and restarts the prescaler. The first increment then arrives DIVISOR clocks after the write.
- R8: timer_irq rises on the increment that makes Count equal to Compare. It stays high until Compare is written, and the cycle after that write it reads low.
- R9: Bit 15 of a Cause (13) read shows timer_irq, ORed with the stored value.
- R10: irq_pending = Status[0] AND any bit of (Status[15:8] AND Cause-read[15:8]). It follows any Status or Cause write in the next cycle.
- R11: mode shows Status bits 4:3, where 00 means kernel, 01 supervisor and 10 user. priv_fault is high when priv_req is high and mode is not 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Move-to strobe |
| wr_wide | input | 1 | 1 = 64-bit move-to, 0 = 32-bit |
| wr_sel | input | 5 | Destination register number |
| wr_data | input | 64 | Source value |
| rd_sel | input | 5 | Source register number for move-from |
| rd_wide | input | 1 | 1 = 64-bit move-from, 0 = 32-bit |
| rd_data | output | 64 | Move-from result (combinational) |
| priv_req | input | 1 | A privileged operation is being attempted |
| priv_fault | output | 1 | Illegal-operation exception request |
| mode | output | 2 | Decoded privilege mode |
| timer_irq | output | 1 | Timer interrupt (line 7) |
| irq_pending | output | 1 | An enabled interrupt is pending |
| rand_idx | output | log2(TLB_ENTRIES) | Replacement index |

## Verification
The assertions check the following on every cycle:
- the replacement index stays inside its band above Wired;
- Count never moves by more than one step unless it is written;
- a Compare write always clears the timer interrupt, and the interrupt only rises while Count matches Compare;
- a narrow read is always sign-consistent;
- a Wired write keeps exactly the low index bits of the source.

Only the bench scenarios can show the rest. These are the exact prescaler cadence, the cycle the interrupt rises, the per-slot masks and ignored writes, the full coverage of the random band, and the pending and fault decode for specific Status and Cause contents.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int NSLOT = 32;
   localparam int DW    = 64;

   localparam logic [4:0] SL_TLBIDX = 5'd0;
   localparam logic [4:0] SL_RANDOM = 5'd1;
   localparam logic [4:0] SL_LO0    = 5'd2;
   localparam logic [4:0] SL_LO1    = 5'd3;
   localparam logic [4:0] SL_CTX    = 5'd4;
   localparam logic [4:0] SL_PGMASK = 5'd5;
   localparam logic [4:0] SL_WIRED  = 5'd6;
   localparam logic [4:0] SL_COUNT  = 5'd9;
   localparam logic [4:0] SL_HI     = 5'd10;
   localparam logic [4:0] SL_CMP    = 5'd11;
   localparam logic [4:0] SL_STATUS = 5'd12;
   localparam logic [4:0] SL_CAUSE  = 5'd13;
   localparam logic [4:0] SL_PRID   = 5'd15;
   localparam logic [4:0] SL_CONFIG = 5'd16;

   localparam logic [63:0] PGMASK_KEEP = 64'h0000_0000_01FF_E000;
   localparam logic [63:0] HI_KEEP     = 64'hC000_00FF_FFFF_E0FF;
   localparam logic [63:0] LO_KEEP     = 64'h0000_0000_3FFF_FFFF;

   typedef enum logic [1:0] {
      MODE_KERNEL = 2'b00,
      MODE_SUPER  = 2'b01,
      MODE_USER   = 2'b10,
      MODE_RSVD   = 2'b11
   } priv_mode_e;

   function automatic logic [63:0] sext32(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   // Slots held in the generic storage array; the others live elsewhere
   // (timer, replacement logic) or are constants.
   function automatic logic slot_is_stored(input int s);
      return !(s == 1 || s == 9 || s == 11 || s == 15 || s == 16);
   endfunction

   function automatic logic [63:0] slot_keep(input int s, input int idxw);
      case (s)
         2, 3:    return LO_KEEP;
         5:       return PGMASK_KEEP;
         6:       return (64'd1 << idxw) - 64'd1;
         10:      return HI_KEEP;
         default: return '1;
      endcase
   endfunction

endpackage

// File: rtl/sysctl_slots.sv
module sysctl_slots
   import sysctl_pkg::*;
#(
   parameter int IDXW = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [4:0]  wr_sel,
   input  logic [63:0] wr_val,
   output logic [63:0] slot_q [NSLOT]
);

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      if (slot_is_stored(g)) begin : g_rw
         localparam logic [63:0] KEEP = slot_keep(g, IDXW);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q[g] <= '0;
            else if (wr_en && (wr_sel == 5'(g)))
               slot_q[g] <= wr_val & KEEP;
         end
      end else begin : g_none
         assign slot_q[g] = '0;
      end
   end

endmodule

// File: rtl/sysctl_timer.sv
module sysctl_timer #(
   parameter int DIVISOR = 2,
   parameter int CW      = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_wr,
   input  logic          cmp_wr,
   input  logic [CW-1:0] wval,
   output logic [CW-1:0] count_q,
   output logic [CW-1:0] compare_q,
   output logic          irq_q
);

   localparam int PW = (DIVISOR > 1) ? $clog2(DIVISOR) : 1;

   logic tick;
   logic past_ok;

   initial begin
      assert (DIVISOR >= 1) else $error("sysctl_timer: DIVISOR must be at least 1");
   end

   if (DIVISOR == 1) begin : g_nodiv
      assign tick = 1'b1;
   end else begin : g_div
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pre_q <= '0;
         else if (cnt_wr || (pre_q == PW'(DIVISOR - 1)))
            pre_q <= '0;
         else
            pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PW'(DIVISOR - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q   <= '0;
         compare_q <= '0;
         irq_q     <= 1'b0;
         past_ok   <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         if (cnt_wr)
            count_q <= wval;
         else if (tick)
            count_q <= count_q + 1'b1;
         if (cmp_wr)
            compare_q <= wval;
         if (cmp_wr)
            irq_q <= 1'b0;
         else if (tick && !cnt_wr && ((count_q + 1'b1) == compare_q))
            irq_q <= 1'b1;
      end
   end

   // R8
   cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr |=> !irq_q);

   // R8
   irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(irq_q)) |-> (count_q == compare_q));

   // R7
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(cnt_wr)) |->
         ((count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1)));

endmodule

// File: rtl/sysctl_random.sv
module sysctl_random #(
   parameter int TLB_ENTRIES = 16,
   parameter int IDXW        = 4,
   parameter int CNTW        = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IDXW-1:0] wired,
   output logic [IDXW-1:0] rand_idx
);

   localparam logic [IDXW:0] ENT = (IDXW + 1)'(TLB_ENTRIES);

   logic [CNTW-1:0] free_q;
   logic [IDXW:0]   span;
   logic [CNTW-1:0] divisor;
   logic [IDXW:0]   rem;
   logic [IDXW:0]   rand_sum;

   initial begin
      assert (CNTW > IDXW) else $error("sysctl_random: CNTW must exceed IDXW");
      assert (TLB_ENTRIES >= 2) else $error("sysctl_random: need two entries");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         free_q <= '0;
      else
         free_q <= free_q + 1'b1;
   end

   always_comb begin
      span    = ENT - {1'b0, wired};
      divisor = (span == '0) ? CNTW'(1) : {{(CNTW - IDXW - 1){1'b0}}, span};
      rem     = (IDXW + 1)'(free_q % divisor);
      if ({1'b0, wired} >= (ENT - 1'b1))
         rand_sum = ENT - 1'b1;
      else
         rand_sum = {1'b0, wired} + rem;
   end

   assign rand_idx = rand_sum[IDXW-1:0];

   // R3
   rand_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rand_sum < ENT) &&
      ((rand_sum >= {1'b0, wired}) || ({1'b0, wired} >= ENT)));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
   import sysctl_pkg::*;
#(
   parameter int          TLB_ENTRIES = 16,
   parameter int          DIVISOR     = 2,
   parameter int          FREE_W      = 8,
   parameter logic [63:0] PRID_VAL    = 64'h0000_0000_0000_0A31,
   parameter logic [63:0] CONFIG_VAL  = 64'h0000_0000_8000_C0DE,
   localparam int         IDXW        = $clog2(TLB_ENTRIES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_wide,
   input  logic [4:0]      wr_sel,
   input  logic [63:0]     wr_data,
   input  logic [4:0]      rd_sel,
   input  logic            rd_wide,
   output logic [63:0]     rd_data,
   input  logic            priv_req,
   output logic            priv_fault,
   output logic [1:0]      mode,
   output logic            timer_irq,
   output logic            irq_pending,
   output logic [IDXW-1:0] rand_idx
);

   logic [63:0]     wval;
   logic [63:0]     slot_q [NSLOT];
   logic [31:0]     count_q;
   logic [31:0]     compare_q;
   logic [IDXW-1:0] wired;
   logic [63:0]     status_v;
   logic [63:0]     cause_v;
   logic [63:0]     raw;
   logic            cnt_wr;
   logic            cmp_wr;

   initial begin
      assert (TLB_ENTRIES >= 2 && TLB_ENTRIES <= 1024)
         else $error("sysctl_regbank: TLB_ENTRIES out of range");
   end

   // 32-bit moves carry only the low half of the source
   assign wval   = wr_wide ? wr_data : {32'b0, wr_data[31:0]};
   assign cnt_wr = wr_en && (wr_sel == SL_COUNT);
   assign cmp_wr = wr_en && (wr_sel == SL_CMP);

   sysctl_slots #(.IDXW(IDXW)) i_slots (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_val (wval),
      .slot_q (slot_q)
   );

   sysctl_timer #(.DIVISOR(DIVISOR), .CW(32)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_wr    (cnt_wr),
      .cmp_wr    (cmp_wr),
      .wval      (wval[31:0]),
      .count_q   (count_q),
      .compare_q (compare_q),
      .irq_q     (timer_irq)
   );

   assign wired = slot_q[SL_WIRED][IDXW-1:0];

   sysctl_random #(.TLB_ENTRIES(TLB_ENTRIES), .IDXW(IDXW), .CNTW(FREE_W)) i_random (
      .clk      (clk),
      .rst_n    (rst_n),
      .wired    (wired),
      .rand_idx (rand_idx)
   );

   assign status_v = slot_q[SL_STATUS];
   assign cause_v  = slot_q[SL_CAUSE] | (64'(timer_irq) << 15);

   always_comb begin
      case (rd_sel)
         SL_RANDOM: raw = {{(64 - IDXW){1'b0}}, rand_idx};
         SL_COUNT:  raw = sext32(count_q);
         SL_CMP:    raw = sext32(compare_q);
         SL_CAUSE:  raw = cause_v;
         SL_PRID:   raw = PRID_VAL;
         SL_CONFIG: raw = CONFIG_VAL;
         default:   raw = slot_q[rd_sel];
      endcase
   end

   assign rd_data     = rd_wide ? raw : sext32(raw[31:0]);
   assign mode        = status_v[4:3];
   assign priv_fault  = priv_req && (mode != MODE_KERNEL);
   assign irq_pending = status_v[0] && (|(status_v[15:8] & cause_v[15:8]));

   // R6
   narrow_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_wide |-> (rd_data[63:32] == {32{rd_data[31]}}));

   // R4
   wired_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == SL_WIRED)) |=> (wired == $past(wval[IDXW-1:0])));

endmodule

// File: tb/test_sysctl_regbank.sv
`timescale 1ns/1ps
module test_sysctl_regbank;
   import sysctl_pkg::*;

   localparam int          ENT  = 16;
   localparam logic [63:0] PRID = 64'h0000_0000_0000_0A31;
   localparam logic [63:0] CFG  = 64'h0000_0000_8000_C0DE;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, wr_wide, rd_wide, priv_req;
   logic [4:0]  wr_sel, rd_sel;
   logic [63:0] wr_data, rd_data;
   logic        priv_fault, timer_irq, irq_pending;
   logic [1:0]  mode;
   logic [3:0]  rand_idx;

   always #2.5 clk = ~clk;

   sysctl_regbank #(
      .TLB_ENTRIES(ENT), .DIVISOR(2), .FREE_W(8),
      .PRID_VAL(PRID), .CONFIG_VAL(CFG)
   ) i_sysctl_regbank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide),
      .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_wide(rd_wide),
      .rd_data(rd_data), .priv_req(priv_req), .priv_fault(priv_fault),
      .mode(mode), .timer_irq(timer_irq), .irq_pending(irq_pending),
      .rand_idx(rand_idx)
   );

   // kinds: 0 rd_data, 1 timer_irq, 2 irq_pending, 3 priv_fault, 4 mode,
   //        5 rand_idx exact, 6 rand_idx inside [exp, ENT-1]
   typedef struct {
      int          kind;
      logic [63:0] exp;
      string       tag;
   } exp_t;

   exp_t       q[$];
   int         checks = 0;
   int         errors = 0;
   logic [15:0] seen;
   bit         done = 0;

   task automatic note(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares every queued expectation just after the driving edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            exp_t it;
            logic [63:0] act;
            it = q.pop_front();
            case (it.kind)
               0: act = rd_data;
               1: act = {63'b0, timer_irq};
               2: act = {63'b0, irq_pending};
               3: act = {63'b0, priv_fault};
               4: act = {62'b0, mode};
               default: act = {60'b0, rand_idx};
            endcase
            if (it.kind == 6) begin
               seen[rand_idx] = 1'b1;
               note((act >= it.exp) && (act < 64'(ENT)), it.tag, act, it.exp);
            end else begin
               note(act == it.exp, it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] sel, input logic wide, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_wide = wide; wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic exp_rd(input logic [4:0] sel, input logic wide,
                         input logic [63:0] e, input string tag);
      exp_t it;
      rd_sel = sel; rd_wide = wide;
      it.kind = 0; it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic exp_out(input int kind, input logic [63:0] e, input string tag);
      exp_t it;
      it.kind = kind; it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_wide = 1'b1; wr_sel = '0; wr_data = '0;
      rd_sel = '0; rd_wide = 1'b1; priv_req = 1'b0; seen = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int s = 0; s < 32; s++) begin
         if (s == 1 || s == 9) continue;
         step();
         if (s == 15)      exp_rd(5'(s), 1'b1, PRID, "R1");
         else if (s == 16) exp_rd(5'(s), 1'b1, CFG, "R1");
         else              exp_rd(5'(s), 1'b1, 64'h0, "R1");
      end

      // R2 read-only identity and configuration
      wr(SL_PRID, 1'b1, '1);
      wr(SL_CONFIG, 1'b1, 64'h0);
      step(); exp_rd(SL_PRID, 1'b1, PRID, "R2");
      step(); exp_rd(SL_CONFIG, 1'b1, CFG, "R2");
      step(); exp_rd(SL_CONFIG, 1'b0, 64'hFFFF_FFFF_8000_C0DE, "R6");

      // R5 / R6 widths
      wr(SL_TLBIDX, 1'b1, 64'h1234_5678_8000_0001);
      step(); exp_rd(SL_TLBIDX, 1'b1, 64'h1234_5678_8000_0001, "R5");
      step(); exp_rd(SL_TLBIDX, 1'b0, 64'hFFFF_FFFF_8000_0001, "R6");
      wr(SL_CTX, 1'b0, 64'hAAAA_BBBB_7000_0002);
      step(); exp_rd(SL_CTX, 1'b1, 64'h0000_0000_7000_0002, "R5");

      // R4 masks
      wr(SL_PGMASK, 1'b1, '1);
      step(); exp_rd(SL_PGMASK, 1'b1, 64'h0000_0000_01FF_E000, "R4");
      wr(SL_HI, 1'b1, '1);
      step(); exp_rd(SL_HI, 1'b1, 64'hC000_00FF_FFFF_E0FF, "R4");
      wr(SL_LO0, 1'b1, '1);
      step(); exp_rd(SL_LO0, 1'b1, 64'h0000_0000_3FFF_FFFF, "R4");
      wr(SL_LO1, 1'b0, '1);
      step(); exp_rd(SL_LO1, 1'b1, 64'h0000_0000_3FFF_FFFF, "R4");

      // R7 prescaler cadence
      wr(SL_COUNT, 1'b1, 64'd100);
      for (int k = 0; k < 6; k++) begin
         step(); exp_rd(SL_COUNT, 1'b1, 64'(100 + k / 2), "R7");
      end

      // R6 count sign extension through a wide read
      wr(SL_COUNT, 1'b1, 64'h0000_0000_8000_0000);
      step(); exp_rd(SL_COUNT, 1'b1, 64'hFFFF_FFFF_8000_0000, "R6");

      // R8 timer interrupt
      wr(SL_CMP, 1'b1, 64'd5);
      wr(SL_COUNT, 1'b1, 64'd0);
      for (int k = 0; k < 14; k++) begin
         step();
         exp_rd(SL_COUNT, 1'b1, 64'(k / 2), "R7");
         exp_out(1, (k >= 10) ? 64'd1 : 64'd0, "R8");
      end

      // R9 / R10 with the timer interrupt high
      wr(SL_STATUS, 1'b1, 64'h8001);
      step(); exp_out(2, 64'd1, "R10");
      exp_rd(SL_CAUSE, 1'b1, 64'h8000, "R9");
      wr(SL_CMP, 1'b1, 64'h0000_0001_8000_0000);
      step(); exp_out(1, 64'd0, "R8");
      exp_out(2, 64'd0, "R10");
      step(); exp_rd(SL_CMP, 1'b1, 64'hFFFF_FFFF_8000_0000, "R6");
      exp_out(1, 64'd0, "R8");
      step(); exp_rd(SL_CAUSE, 1'b1, 64'h0, "R9");
      wr(SL_CAUSE, 1'b1, 64'h100);
      wr(SL_STATUS, 1'b1, 64'h101);
      step(); exp_out(2, 64'd1, "R10");
      wr(SL_STATUS, 1'b1, 64'h100);
      step(); exp_out(2, 64'd0, "R10");

      // R11 mode and privilege fault
      priv_req = 1'b1;
      wr(SL_STATUS, 1'b1, 64'h10);
      step(); exp_out(4, 64'd2, "R11");
      exp_out(3, 64'd1, "R11");
      wr(SL_STATUS, 1'b1, 64'h08);
      step(); exp_out(4, 64'd1, "R11");
      exp_out(3, 64'd1, "R11");
      wr(SL_STATUS, 1'b1, 64'h0);
      step(); exp_out(4, 64'd0, "R11");
      exp_out(3, 64'd0, "R11");
      priv_req = 1'b0;
      step(); exp_out(3, 64'd0, "R11");

      // R3 replacement index, Wired = 0
      step(); #2; seen = '0;
      for (int k = 0; k < 20; k++) begin
         step(); exp_out(6, 64'd0, "R3");
      end
      step(); #2;
      note(seen == 16'hFFFF, "R3", {48'b0, seen}, 64'hFFFF);

      // R3 with Wired = 10
      wr(SL_WIRED, 1'b1, 64'd10);
      step(); #2; seen = '0;
      for (int k = 0; k < 20; k++) begin
         step(); exp_out(6, 64'd10, "R3");
      end
      step(); #2;
      note(seen == 16'hFC00, "R3", {48'b0, seen}, 64'hFC00);

      // R4 wired mask, R3 clamp at the top entry, R2 random ignores writes
      wr(SL_WIRED, 1'b1, '1);
      step(); exp_rd(SL_WIRED, 1'b1, 64'hF, "R4");
      exp_out(5, 64'd15, "R3");
      wr(SL_RANDOM, 1'b1, 64'h0);
      step(); exp_rd(SL_RANDOM, 1'b0, 64'd15, "R2");
      step(); exp_rd(SL_WIRED, 1'b1, 64'hF, "R2");
      exp_out(5, 64'd15, "R3");

      step(); #2;
      finish_run();
   end

endmodule